// File: doc/BRIEF.md
# Two-Speed Angle Command Register File

This block holds the commanded shaft angles for a bank of digital-to-synchro channels. Each angle is a 16-bit word with one LSB equal to 360/65536 degrees. A host loads the angles over a bus that moves either one byte or one 16-bit word per access. Each channel owns two byte addresses: the low byte sits at the even address and the high byte at the odd one. In byte mode the high byte is written first and parked in a per-channel buffer. The new angle takes effect only when the low byte arrives. A 16-bit access to the even address loads the whole word in one cycle.

Channels are grouped in adjacent pairs, and each pair has a ratio register. With a ratio of 0 or 1 the two channels of the pair are independent. With a ratio of 2 or more the pair runs two-speed: the host writes only the coarse (even-numbered) channel. In the same clock edge, the fine channel takes the low 16 bits of the coarse angle times the ratio, so it wraps modulo one turn. Every angle commit raises a one-cycle pulse for that channel, which the rotation logic uses to halt any motion running on it. The read side returns the measured wrap-around angles supplied at an input port. It uses a byte-freeze scheme: reading a high byte holds the matching low byte until that low byte is read.

Top module: `angle_cmd_regs`

## Requirements
- R1: After reset every committed angle is 0, every write pulse is low and every ratio register reads 0.
- R2: A 16-bit write to offset 2c loads channel c with the whole data word. A 16-bit write to an odd offset changes nothing.
- R3: A byte write to offset 2c+1 stores the byte in channel c's own high buffer, with no angle change and no pulse. A byte write to offset 2c commits {buffer, byte} as channel c's angle.
- R4: The ratio of pair p lives at offset 2*NUM_CH+p. A write there stores the low 8 bits of the data, and a read there returns them zero-extended.
- R5: With a ratio of 0 or 1, the two channels of a pair are written and held independently.
- R6: With a ratio of 2 or more, a commit to the coarse channel 2p also sets channel 2p+1 to the low 16 bits of angle*ratio at the same clock edge.
- R7: With a ratio of 2 or more, writes to the fine channel's two offsets are ignored. This includes its high buffer, and no pulse is raised.
- R8: A change of ratio does not alter any committed angle.
- R9: The pulse of channel c is high for exactly the cycle in which a newly committed angle first appears on channel c. An angle never changes without that pulse.
- R10: A byte read of offset 2c+1 returns the high byte of wrap-around angle c and freezes its low byte. A later byte read of offset 2c returns the frozen byte and releases the freeze. A 16-bit read of offset 2c returns the live word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| rd_en | input | 1 | Read strobe; updates the low-byte freeze |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = byte read |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 16 | Combinational read data |
| wrap_angle | input | NUM_CH*16 | Measured wrap-around angles, channel c at bits 16c+15:16c |
| angle_out | output | NUM_CH*16 | Committed angles, channel c at bits 16c+15:16c |
| angle_wr_pulse | output | NUM_CH | Per-channel commit pulse |

## Verification
The bench uses the default build: eight channels (four pairs), 8-bit ratios, and the read freeze enabled. With this build it can reach a full-scale ratio of 255 on the top pair and a product that overflows past 16 bits. It also reaches byte writes pending in two channels at once, and a freeze that is held while the wrap-around input changes. Pairs in single-speed and two-speed mode are mixed in one run, to show that the ratio of one pair leaves its neighbours alone.

// File: rtl/angle_cmd_pkg.sv
package angle_cmd_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_WIDE = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic en, input logic wide, input logic odd);
      if (!en)       return ACC_NONE;
      else if (wide) return odd ? ACC_NONE : ACC_WIDE;
      else           return odd ? ACC_HI : ACC_LO;
   endfunction
endpackage

// File: rtl/acr_pair.sv
module acr_pair
   import angle_cmd_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int ANGLE_W = 16,
   parameter int RATIO_W = 8,
   parameter int ADDR_W  = 5,
   parameter int PAIR    = 0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_wide,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [ANGLE_W-1:0] wr_data,
   output logic [ANGLE_W-1:0] coarse_o,
   output logic [ANGLE_W-1:0] fine_o,
   output logic [1:0]         pulse_o,
   output logic [RATIO_W-1:0] ratio_o
);
   localparam int COARSE_CH = 2 * PAIR;
   localparam int FINE_CH   = COARSE_CH + 1;
   localparam int RATIO_OFS = 2 * NUM_CH + PAIR;
   localparam int PROD_W    = ANGLE_W + RATIO_W;

   logic [BYTE_W-1:0]  hold_c, hold_f;
   logic [ANGLE_W-1:0] coarse_q, fine_q;
   logic [RATIO_W-1:0] ratio_q;
   logic [1:0]         pulse_q;

   acc_kind_e   acc;
   logic [ADDR_W-2:0] ch_sel;
   logic        hit_c, hit_f, two_speed;
   logic        c_commit, f_commit, c_hold, f_hold, r_write;
   logic [ANGLE_W-1:0] new_c, new_f;
   logic [PROD_W-1:0]  prod;

   always_comb begin
      acc       = classify(wr_en, wr_wide, wr_addr[0]);
      ch_sel    = wr_addr[ADDR_W-1:1];
      hit_c     = (ch_sel == (ADDR_W-1)'(COARSE_CH)) && (wr_addr < ADDR_W'(2 * NUM_CH));
      hit_f     = (ch_sel == (ADDR_W-1)'(FINE_CH)) && (wr_addr < ADDR_W'(2 * NUM_CH));
      two_speed = (ratio_q > RATIO_W'(1));
      c_commit  = hit_c && (acc == ACC_LO || acc == ACC_WIDE);
      c_hold    = hit_c && (acc == ACC_HI);
      f_commit  = hit_f && (acc == ACC_LO || acc == ACC_WIDE) && !two_speed;
      f_hold    = hit_f && (acc == ACC_HI) && !two_speed;
      r_write   = wr_en && (wr_addr == ADDR_W'(RATIO_OFS));
      new_c     = (acc == ACC_WIDE) ? wr_data : {hold_c, wr_data[BYTE_W-1:0]};
      new_f     = (acc == ACC_WIDE) ? wr_data : {hold_f, wr_data[BYTE_W-1:0]};
      prod      = PROD_W'(new_c) * PROD_W'(ratio_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_c   <= '0;
         hold_f   <= '0;
         coarse_q <= '0;
         fine_q   <= '0;
         ratio_q  <= '0;
         pulse_q  <= '0;
      end else begin
         pulse_q <= {f_commit || (c_commit && two_speed), c_commit};
         if (c_hold) hold_c <= wr_data[BYTE_W-1:0];
         if (f_hold) hold_f <= wr_data[BYTE_W-1:0];
         if (c_commit) coarse_q <= new_c;
         if (f_commit) fine_q <= new_f;
         else if (c_commit && two_speed) fine_q <= prod[ANGLE_W-1:0];
         if (r_write) ratio_q <= wr_data[RATIO_W-1:0];
      end
   end

   assign coarse_o = coarse_q;
   assign fine_o   = fine_q;
   assign pulse_o  = pulse_q;
   assign ratio_o  = ratio_q;

   // R9: an angle never moves without its pulse
   p_coarse_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_q != $past(coarse_q)) |-> pulse_q[0]);
   p_fine_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_q != $past(fine_q)) |-> pulse_q[1]);
   // R3: a high-byte write leaves the committed coarse angle alone
   p_hi_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_wide && wr_addr == ADDR_W'(2 * COARSE_CH + 1)) |=> $stable(coarse_q));
   // R7: in two-speed mode the fine offsets raise no pulse by themselves
   p_fine_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (two_speed && wr_en && wr_addr[ADDR_W-1:1] == (ADDR_W-1)'(FINE_CH)) |=> !pulse_q[1]);
   // R8: a ratio write never moves an angle
   p_ratio_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      r_write |=> ($stable(coarse_q) && $stable(fine_q)));
endmodule

// File: rtl/acr_rdbk.sv
module acr_rdbk
   import angle_cmd_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int ANGLE_W   = 16,
   parameter int RATIO_W   = 8,
   parameter int ADDR_W    = 5,
   parameter bit FREEZE_EN = 1'b1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  logic                      rd_wide,
   input  logic [ADDR_W-1:0]         rd_addr,
   input  logic [NUM_CH*ANGLE_W-1:0] wrap_flat,
   input  logic [NUM_CH/2*RATIO_W-1:0] ratio_flat,
   output logic [ANGLE_W-1:0]        rd_data
);
   localparam int NUM_PAIR = NUM_CH / 2;

   acc_kind_e          acc;
   logic [ANGLE_W-1:0] live;
   logic               live_hit;
   logic [ADDR_W-2:0]  ch_sel;
   logic               frz_valid;
   logic [ADDR_W-2:0]  frz_ch;
   logic [BYTE_W-1:0]  frz_lo;

   always_comb begin
      acc      = classify(rd_en || !rd_en, rd_wide, rd_addr[0]);
      ch_sel   = rd_addr[ADDR_W-1:1];
      live     = '0;
      live_hit = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_sel == (ADDR_W-1)'(c)) begin
            live     = wrap_flat[c*ANGLE_W +: ANGLE_W];
            live_hit = 1'b1;
         end
      end
      rd_data = '0;
      if (live_hit) begin
         case (acc)
            ACC_WIDE: rd_data = live;
            ACC_HI:   rd_data = ANGLE_W'(live[ANGLE_W-1:BYTE_W]);
            ACC_LO:   rd_data = (frz_valid && frz_ch == ch_sel) ? ANGLE_W'(frz_lo)
                                                                : ANGLE_W'(live[BYTE_W-1:0]);
            default:  rd_data = '0;
         endcase
      end
      for (int p = 0; p < NUM_PAIR; p++) begin
         if (rd_addr == ADDR_W'(2 * NUM_CH + p))
            rd_data = ANGLE_W'(ratio_flat[p*RATIO_W +: RATIO_W]);
      end
   end

   generate
      if (FREEZE_EN) begin : g_freeze
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               frz_valid <= 1'b0;
               frz_ch    <= '0;
               frz_lo    <= '0;
            end else if (rd_en && live_hit && acc == ACC_HI) begin
               frz_valid <= 1'b1;
               frz_ch    <= ch_sel;
               frz_lo    <= live[BYTE_W-1:0];
            end else if (rd_en && live_hit && acc == ACC_LO && frz_ch == ch_sel) begin
               frz_valid <= 1'b0;
            end
         end

         // R10: a frozen low byte keeps its value until released or replaced
         p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (frz_valid && !(rd_en && !rd_wide)) |=> (frz_valid && $stable(frz_lo)));
      end else begin : g_live
         assign frz_valid = 1'b0;
         assign frz_ch    = '0;
         assign frz_lo    = '0;
      end
   endgenerate
endmodule

// File: rtl/angle_cmd_regs.sv
module angle_cmd_regs
#(
   parameter int NUM_CH    = 8,
   parameter int ANGLE_W   = 16,
   parameter int RATIO_W   = 8,
   parameter bit FREEZE_EN = 1'b1,
   parameter int ADDR_W    = $clog2(2 * NUM_CH + NUM_CH / 2)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_wide,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [15:0]               wr_data,
   input  logic                      rd_en,
   input  logic                      rd_wide,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [15:0]               rd_data,
   input  logic [NUM_CH*16-1:0]      wrap_angle,
   output logic [NUM_CH*16-1:0]      angle_out,
   output logic [NUM_CH-1:0]         angle_wr_pulse
);
   localparam int NUM_PAIR = NUM_CH / 2;

   initial begin
      chk_even: assert (NUM_CH >= 2 && NUM_CH % 2 == 0)
         else $error("NUM_CH must be an even count of at least 2");
      chk_width: assert (ANGLE_W == 16)
         else $error("angles are 16-bit words");
      chk_ratio: assert (RATIO_W >= 2 && RATIO_W <= 8)
         else $error("RATIO_W must lie in 2..8");
      chk_addr: assert ((1 << ADDR_W) >= 2 * NUM_CH + NUM_PAIR)
         else $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_PAIR*RATIO_W-1:0] ratio_flat;

   generate
      for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
         acr_pair #(
            .NUM_CH (NUM_CH), .ANGLE_W(ANGLE_W), .RATIO_W(RATIO_W),
            .ADDR_W (ADDR_W), .PAIR   (p)
         ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_wide  (wr_wide),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .coarse_o (angle_out[(2*p)*ANGLE_W +: ANGLE_W]),
            .fine_o   (angle_out[(2*p+1)*ANGLE_W +: ANGLE_W]),
            .pulse_o  (angle_wr_pulse[2*p +: 2]),
            .ratio_o  (ratio_flat[p*RATIO_W +: RATIO_W])
         );
      end
   endgenerate

   acr_rdbk #(
      .NUM_CH(NUM_CH), .ANGLE_W(ANGLE_W), .RATIO_W(RATIO_W),
      .ADDR_W(ADDR_W), .FREEZE_EN(FREEZE_EN)
   ) u_rdbk (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .rd_wide    (rd_wide),
      .rd_addr    (rd_addr),
      .wrap_flat  (wrap_angle),
      .ratio_flat (ratio_flat),
      .rd_data    (rd_data)
   );

   // R9: a single write can touch at most one pair, so at most two pulses
   p_pulse_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(angle_wr_pulse) <= 2);
   // R9: a pulse lasts one cycle unless another write follows
   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (angle_wr_pulse == '0));
endmodule

// File: tb/sim_angle_cmd_regs.sv
module sim_angle_cmd_regs;
   localparam int NCH = 8;
   localparam int AW  = 5;

   typedef struct packed {
      logic          wide;
      logic [AW-1:0] addr;
      logic [15:0]   data;
      logic [2:0]    ch;
      logic [15:0]   exp;
      logic [7:0]    pmask;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 5'd0,  16'h1234, 3'd0, 16'h1234, 8'h01}, // R2 wide write ch0
      '{1'b0, 5'd1,  16'h00AB, 3'd0, 16'h1234, 8'h00}, // R3 hi byte buffered only
      '{1'b0, 5'd0,  16'h00CD, 3'd0, 16'hABCD, 8'h01}, // R3 lo byte commits
      '{1'b0, 5'd16, 16'h0024, 3'd0, 16'hABCD, 8'h00}, // R4 R8 ratio 36 on pair 0
      '{1'b1, 5'd0,  16'h0100, 3'd1, 16'h2400, 8'h03}, // R6 fine = 0x100*36
      '{1'b1, 5'd0,  16'h1C72, 3'd1, 16'h0008, 8'h03}, // R6 product wraps
      '{1'b1, 5'd2,  16'h5555, 3'd1, 16'h0008, 8'h00}, // R7 fine wide write ignored
      '{1'b0, 5'd3,  16'h0077, 3'd1, 16'h0008, 8'h00}, // R7 fine hi byte ignored
      '{1'b0, 5'd16, 16'h0001, 3'd1, 16'h0008, 8'h00}, // R8 ratio back to 1
      '{1'b0, 5'd2,  16'h0011, 3'd1, 16'h0011, 8'h02}, // R5 R7 fine buffer stayed 0
      '{1'b1, 5'd0,  16'h2000, 3'd1, 16'h0011, 8'h01}, // R5 single speed
      '{1'b0, 5'd16, 16'h0000, 3'd0, 16'h2000, 8'h00}, // R4 ratio 0
      '{1'b1, 5'd0,  16'h0300, 3'd1, 16'h0011, 8'h01}, // R5 ratio 0 is single speed
      '{1'b0, 5'd19, 16'h00FF, 3'd7, 16'h0000, 8'h00}, // R4 ratio 255 on pair 3
      '{1'b1, 5'd12, 16'hFFFF, 3'd7, 16'hFF01, 8'hC0}, // R6 full-scale ratio
      '{1'b1, 5'd17, 16'h0102, 3'd3, 16'h0000, 8'h00}, // R4 wide ratio write keeps low byte
      '{1'b1, 5'd4,  16'h8001, 3'd3, 16'h0002, 8'h0C}, // R6 ratio 2 wraps
      '{1'b0, 5'd9,  16'h005A, 3'd4, 16'h0000, 8'h00}, // R3 hi ch4
      '{1'b0, 5'd11, 16'h006B, 3'd5, 16'h0000, 8'h00}, // R3 hi ch5, own buffer
      '{1'b1, 5'd1,  16'hFFFF, 3'd0, 16'h0300, 8'h00}  // R2 wide write to odd offset ignored
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_wide = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [NCH*16-1:0] wrap_angle = '0;
   logic [NCH*16-1:0] angle_out;
   logic [NCH-1:0] angle_wr_pulse;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   angle_cmd_regs u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_wide(rd_wide), .rd_addr(rd_addr),
      .rd_data(rd_data), .wrap_angle(wrap_angle), .angle_out(angle_out),
      .angle_wr_pulse(angle_wr_pulse)
   );

   function automatic logic [15:0] ang(input int c);
      return angle_out[c*16 +: 16];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic wide, input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_wide = wide; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int c = 0; c < NCH; c++) check("R1 angle", ang(c), 16'h0000);
      check("R1 pulse", 16'(angle_wr_pulse), 16'h0000);
      rst_n = 1'b1;
      rd_wide = 1'b0; rd_addr = 5'd16;
      #1 check("R1 ratio", rd_data, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         do_write(VECS[i].wide, VECS[i].addr, VECS[i].data);
         check($sformatf("vec %0d angle", i), ang(int'(VECS[i].ch)), VECS[i].exp);
         check($sformatf("vec %0d R9 pulse", i), 16'(angle_wr_pulse), 16'(VECS[i].pmask));
      end

      // R3 both pending buffers commit independently
      do_write(1'b0, 5'd8, 16'h0001);
      check("R3 ch4", ang(4), 16'h5A01);
      check("R9 pulse ch4", 16'(angle_wr_pulse), 16'h0010);
      do_write(1'b0, 5'd10, 16'h0002);
      check("R3 ch5", ang(5), 16'h6B02);
      @(negedge clk);
      check("R9 pulse drops", 16'(angle_wr_pulse), 16'h0000);

      // R4 ratio readback
      rd_addr = 5'd19; #1 check("R4 ratio3", rd_data, 16'h00FF);
      rd_addr = 5'd17; #1 check("R4 ratio1", rd_data, 16'h0002);

      // R10 freeze on high-byte read
      wrap_angle[15:0] = 16'h1357;
      @(negedge clk);
      rd_en = 1'b1; rd_wide = 1'b0; rd_addr = 5'd1;
      #1 check("R10 hi byte", rd_data, 16'h0013);
      @(negedge clk);
      wrap_angle[15:0] = 16'h2468;
      rd_addr = 5'd0;
      #1 check("R10 frozen lo", rd_data, 16'h0057);
      @(negedge clk);
      #1 check("R10 released lo", rd_data, 16'h0068);
      rd_wide = 1'b1;
      #1 check("R10 wide live", rd_data, 16'h2468);
      rd_en = 1'b0; rd_wide = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule